// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-line priority interrupt cores into one sixteen-line system. The second core (the slave) does not reach the CPU directly: whenever it has a winning request, that fact is forced into line 2 of the first core (the master) as an edge-style request, re-armed every cycle. The CPU sees a single interrupt output, which is recomputed every cycle from the master's priority resolver.

Software programs the pair through a byte-wide read/write bus with a 16-bit address. Each core has a command port and a data port. A separate pair of addresses reaches the two trigger-mode registers, which choose per line between edge and level sensing. Only single-byte accesses take effect.

The CPU fetches a vector through an acknowledge request. The acknowledge path resolves the cascade, updates the in-service state of one or both cores, and returns an 8-bit vector on the following cycle. When nothing is pending, a core answers with line 7 of its own vector range.

Top module: `picPair`

## Requirements
- R1: After reset, `cpuIrq` and `ackValid` are 0, and every mapped register reads back 0.
- R2: Ports are decoded from the full 16-bit address. 0x0020 and 0x0021 select the master, and 0x00A0 and 0x00A1 select the slave; address bit 7 picks the core and bit 0 picks the port (0 = command, 1 = data). 0x04D0 selects the master trigger register and 0x04D1 the slave's. Any other address ignores writes and reads 0.
- R3: A write to a trigger register stores the data ANDed with 0xF8 for the master and with 0xDE for the slave. Bit n = 1 makes line n level-sensed.
- R4: Only an access with `busBytes` == 1 takes effect. Any other size leaves all state unchanged and reads 0.
- R5: An edge-sensed line sets its request bit on a 0-to-1 transition. A level-sensed line's request bit follows the input, and an acknowledge does not clear it.
- R6: A request competes only while its mask bit is 0. Line 0 has the highest priority. A request wins only if its priority is strictly higher than that of every in-service line. With nested mode set, the master ignores its in-service bit 2 in this comparison.
- R7: `cpuIrq` is 1 in exactly those cycles in which the master has a winning request.
- R8: In any cycle where the slave has a winner, master request bit 2 is set at the next clock edge.
- R9: `ackReq` high in a cycle gives `ackValid` high in the next cycle. If the master winner is a line other than 2, `ackVector` = master base + line, the winner's in-service bit is set, and an edge-sensed winner's request bit is cleared.
- R10: If the master winner is line 2 and the slave has a winner, both cores are acknowledged and `ackVector` = slave base + slave line.
- R11: If the master winner is line 2 and the slave has no winner, `ackVector` = slave base + 7.
- R12: If the master has no winner, `ackVector` = master base + 7 and no in-service bit changes.
- R13: A command-port write with bit 4 set starts initialisation. It clears the request, mask and in-service registers, the base, and the mode bits. The next data write sets the base, with bits 2:0 dropped. The next data write is consumed. If bit 0 of the start word was 1, one more data write follows, where bit 1 selects auto-EOI and bit 4 selects nested mode. Outside initialisation, a data write sets the mask. A command write with bits 4:3 = 01 and bit 1 set selects the command-port read (bit 0: 1 = in-service, 0 = request). A command write with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit; with bits 7:5 = 011 it clears in-service bit [2:0].
- R14: In auto-EOI mode, an acknowledge does not set any in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 16 | Interrupt lines; 7:0 to the master, 15:8 to the slave (bit 2 ignored) |
| busAddr | input | 16 | Bus address |
| busBytes | input | 3 | Access size in bytes; only 1 is honoured |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid in the same cycle as `busRd` |
| cpuIrq | output | 1 | Interrupt request to the CPU |
| ackReq | input | 1 | Acknowledge request |
| ackValid | output | 1 | Vector valid, one cycle after `ackReq` |
| ackVector | output | 8 | Acknowledged vector |

## Verification
Read data is combinational, so the bench samples `busRdData` 1 ns after driving the read, with no clock edge in between. The acknowledge vector and `ackValid` appear one edge after `ackReq`. A master line edge raises `cpuIrq` after one edge, and a slave line edge raises it after two, because of the cascade register. The bench drives inputs on falling edges and steps a behavioural model on every rising edge. It compares `cpuIrq`, `ackValid` and `ackVector` against that model on every falling edge, and directed checks with literal values wait out these latencies before sampling.

// File: rtl/picPkg.sv
package picPkg;
  localparam int LINES        = 8;
  localparam int LW           = $clog2(LINES);
  localparam int DATA_W       = LINES;
  localparam int ADDR_W       = 16;
  localparam int LEN_W        = 3;
  localparam int NUM_CORES    = 2;
  localparam int CASCADE_LINE = 2;
  localparam int SPUR_LINE    = LINES - 1;
  localparam logic [ADDR_W-1:0] CORE_ADDR   = 16'h0020;
  localparam logic [ADDR_W-1:0] CORE_IGNORE = 16'h0081;
  localparam logic [ADDR_W-1:0] TRIG_ADDR   = 16'h04D0;
  localparam logic [DATA_W-1:0] M_TRIG_MASK = 8'hF8;
  localparam logic [DATA_W-1:0] S_TRIG_MASK = 8'hDE;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_MASTER, TGT_SLAVE, TGT_TRIG_M, TGT_TRIG_S
  } tgtE;

  typedef struct packed {
    tgtE               tgt;
    logic              oddPort;
    logic              wrEn;
    logic              rdEn;
    logic [DATA_W-1:0] wrData;
    logic              ackM;
    logic              ackS;
  } strobeT;

  typedef struct packed {
    logic              mWin;
    logic [LW-1:0]     mLine;
    logic              sWin;
    logic [LW-1:0]     sLine;
    logic [DATA_W-1:0] mBase;
    logic [DATA_W-1:0] sBase;
  } statusT;

  function automatic logic [LW-1:0] lowestSet(input logic [LINES-1:0] v);
    logic [LW-1:0] idx;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) idx = LW'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/picCore.sv
module picCore
  import picPkg::*;
#(
  parameter bit                IS_MASTER = 1'b1,
  parameter logic [DATA_W-1:0] TRIG_MASK = M_TRIG_MASK
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic              cascadeIn,
  input  logic              cmdWr,
  input  logic              dataWr,
  input  logic              trigWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ack,
  output logic              win,
  output logic [LW-1:0]     winLine,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] cmdRd,
  output logic [DATA_W-1:0] dataRd,
  output logic [DATA_W-1:0] trigRd
);
  typedef enum logic [1:0] {INIT_IDLE, INIT_BASE, INIT_W3, INIT_W4} initStE;

  localparam logic [LINES-1:0]  CAS_BIT   = LINES'(1) << CASCADE_LINE;
  localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(LINES - 1);

  logic [LINES-1:0]  irrQ, isrQ, imrQ, trigQ, lastQ;
  logic [LINES-1:0]  irrD, isrD, lineEff, reqV, isrEff;
  logic [DATA_W-1:0] baseQ;
  initStE            stQ;
  logic              need4Q, sfnmQ, aeoiQ, rselQ;
  logic              isInit, isSel, isOp, eoiNs, eoiSp, ackHit;
  logic [LW-1:0]     reqIdx, isrIdx;

  assign lineEff = IS_MASTER ? (lineIn & ~CAS_BIT) : lineIn;

  // command word classification
  assign isInit = cmdWr && wrData[4];
  assign isSel  = cmdWr && !wrData[4] && wrData[3];
  assign isOp   = cmdWr && !wrData[4] && !wrData[3];
  assign eoiNs  = isOp && (wrData[7:5] == 3'b001);
  assign eoiSp  = isOp && (wrData[7:5] == 3'b011);

  // priority resolver
  always_comb begin
    reqV   = irrQ & ~imrQ;
    isrEff = (IS_MASTER && sfnmQ) ? (isrQ & ~CAS_BIT) : isrQ;
    reqIdx = lowestSet(reqV);
    isrIdx = lowestSet(isrEff);
    win    = (|reqV) && (!(|isrEff) || (reqIdx < isrIdx));
  end
  assign winLine = reqIdx;
  assign ackHit  = ack && win;

  always_comb begin
    irrD = irrQ;
    for (int b = 0; b < LINES; b++) begin
      if (trigQ[b])                     irrD[b] = lineEff[b];
      else if (lineEff[b] && !lastQ[b]) irrD[b] = 1'b1;
    end
    if (cascadeIn) irrD[CASCADE_LINE] = 1'b1;
    if (ackHit && !trigQ[winLine]) irrD[winLine] = 1'b0;
    if (isInit) irrD = '0;
  end

  always_comb begin
    isrD = isrQ;
    if (eoiNs && (|isrQ)) isrD[lowestSet(isrQ)] = 1'b0;
    if (eoiSp) isrD[wrData[LW-1:0]] = 1'b0;
    if (ackHit && !aeoiQ) isrD[winLine] = 1'b1;
    if (isInit) isrD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ   <= '0;
      isrQ   <= '0;
      imrQ   <= '0;
      trigQ  <= '0;
      lastQ  <= '0;
      baseQ  <= '0;
      stQ    <= INIT_IDLE;
      need4Q <= 1'b0;
      sfnmQ  <= 1'b0;
      aeoiQ  <= 1'b0;
      rselQ  <= 1'b0;
    end else begin
      irrQ  <= irrD;
      isrQ  <= isrD;
      lastQ <= isInit ? '0 : lineEff;
      if (trigWr) trigQ <= wrData & TRIG_MASK;
      if (isInit) begin
        imrQ   <= '0;
        baseQ  <= '0;
        need4Q <= wrData[0];
        sfnmQ  <= 1'b0;
        aeoiQ  <= 1'b0;
        rselQ  <= 1'b0;
        stQ    <= INIT_BASE;
      end else begin
        if (isSel && wrData[1]) rselQ <= wrData[0];
        if (dataWr) begin
          case (stQ)
            INIT_IDLE: imrQ <= wrData;
            INIT_BASE: begin
              baseQ <= wrData & BASE_MASK;
              stQ   <= INIT_W3;
            end
            INIT_W3:   stQ <= need4Q ? INIT_W4 : INIT_IDLE;
            INIT_W4: begin
              sfnmQ <= wrData[4];
              aeoiQ <= wrData[1];
              stQ   <= INIT_IDLE;
            end
            default:   stQ <= INIT_IDLE;
          endcase
        end
      end
    end
  end

  assign base   = baseQ;
  assign cmdRd  = rselQ ? isrQ : irrQ;
  assign dataRd = imrQ;
  assign trigRd = trigQ;

  // R6: a winner is always an unmasked pending request
  p_win_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    win |-> (irrQ[winLine] && !imrQ[winLine]));

  // R5: level-sensed request bits mirror the previous cycle's input
  p_level_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> (((irrQ ^ $past(lineEff)) & $past(trigQ)) == '0));

  // R9: an acknowledged winner becomes in service
  p_ack_inservice_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit && !aeoiQ && !cmdWr) |=> isrQ[$past(winLine)]);

  // R14: auto-EOI acknowledge leaves in-service state alone
  p_auto_eoi_r14: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit && aeoiQ && !cmdWr) |=> (isrQ == $past(isrQ)));

  // R8: cascade request lands on line 2
  p_cascade_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeIn && !ackHit && !cmdWr) |=> irrQ[CASCADE_LINE]);
endmodule

// File: rtl/picDatapath.sv
module picDatapath
  import picPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*LINES-1:0]    irqLines,
  input  strobeT                strobe,
  output logic [DATA_W-1:0]     rdData,
  output statusT                st
);
  logic [NUM_CORES-1:0]             winV, casV;
  logic [NUM_CORES-1:0][LW-1:0]     lineV;
  logic [NUM_CORES-1:0][DATA_W-1:0] baseV, cmdRdV, dataRdV, trigRdV;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    localparam bit  MASTER = (c == 0);
    localparam tgtE CORE_T = MASTER ? TGT_MASTER : TGT_SLAVE;
    localparam tgtE TRIG_T = MASTER ? TGT_TRIG_M : TGT_TRIG_S;
    logic cmdWr, dataWr, trigWr, ackIn;

    assign cmdWr  = strobe.wrEn && (strobe.tgt == CORE_T) && !strobe.oddPort;
    assign dataWr = strobe.wrEn && (strobe.tgt == CORE_T) && strobe.oddPort;
    assign trigWr = strobe.wrEn && (strobe.tgt == TRIG_T);
    assign ackIn  = MASTER ? strobe.ackM : strobe.ackS;
    assign casV[c] = MASTER ? winV[NUM_CORES-1] : 1'b0;

    picCore #(
      .IS_MASTER(MASTER),
      .TRIG_MASK(MASTER ? M_TRIG_MASK : S_TRIG_MASK)
    ) i_core (
      .clk      (clk),
      .rstN     (rstN),
      .lineIn   (irqLines[c*LINES +: LINES]),
      .cascadeIn(casV[c]),
      .cmdWr    (cmdWr),
      .dataWr   (dataWr),
      .trigWr   (trigWr),
      .wrData   (strobe.wrData),
      .ack      (ackIn),
      .win      (winV[c]),
      .winLine  (lineV[c]),
      .base     (baseV[c]),
      .cmdRd    (cmdRdV[c]),
      .dataRd   (dataRdV[c]),
      .trigRd   (trigRdV[c])
    );
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) begin
      case (strobe.tgt)
        TGT_MASTER: rdData = strobe.oddPort ? dataRdV[0] : cmdRdV[0];
        TGT_SLAVE:  rdData = strobe.oddPort ? dataRdV[1] : cmdRdV[1];
        TGT_TRIG_M: rdData = trigRdV[0];
        TGT_TRIG_S: rdData = trigRdV[1];
        default:    rdData = '0;
      endcase
    end
  end

  assign st.mWin  = winV[0];
  assign st.mLine = lineV[0];
  assign st.sWin  = winV[1];
  assign st.sLine = lineV[1];
  assign st.mBase = baseV[0];
  assign st.sBase = baseV[1];

  // R4: an access of the wrong size produces no read data
  p_no_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tgt == TGT_NONE) |-> (rdData == '0));
endmodule

// File: rtl/picControl.sv
module picControl
  import picPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LEN_W-1:0]  busBytes,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              ackReq,
  input  statusT            st,
  output strobeT            strobe,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackVector
);
  localparam logic [DATA_W-1:0] SPUR = DATA_W'(SPUR_LINE);

  logic              byteOk, corePort, trigPort;
  logic [DATA_W-1:0] vecD;

  assign byteOk   = (busBytes == LEN_W'(1));
  assign corePort = ((busAddr & ~CORE_IGNORE) == CORE_ADDR);
  assign trigPort = ((busAddr & ~ADDR_W'(1)) == TRIG_ADDR);

  always_comb begin
    strobe.tgt = TGT_NONE;
    if (byteOk && corePort)      strobe.tgt = busAddr[7] ? TGT_SLAVE : TGT_MASTER;
    else if (byteOk && trigPort) strobe.tgt = busAddr[0] ? TGT_TRIG_S : TGT_TRIG_M;
    strobe.oddPort = busAddr[0];
    strobe.wrEn    = busWr;
    strobe.rdEn    = busRd;
    strobe.wrData  = busWrData;
    strobe.ackM    = ackReq;
    strobe.ackS    = ackReq && st.mWin && (st.mLine == LW'(CASCADE_LINE)) && st.sWin;
  end

  // vector resolution through the cascade
  always_comb begin
    vecD = st.mBase | SPUR;
    if (st.mWin) begin
      if (st.mLine == LW'(CASCADE_LINE))
        vecD = st.sWin ? (st.sBase | DATA_W'(st.sLine)) : (st.sBase | SPUR);
      else
        vecD = st.mBase | DATA_W'(st.mLine);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
    end else begin
      ackValid <= ackReq;
      if (ackReq) ackVector <= vecD;
    end
  end

  // R9: response one cycle after request
  p_ack_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackValid);

  // R12: master spurious vector
  p_spur_master_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !st.mWin) |=> (ackVector == ($past(st.mBase) | SPUR)));

  // R11: slave spurious vector
  p_spur_slave_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && st.mWin && (st.mLine == LW'(CASCADE_LINE)) && !st.sWin)
      |=> (ackVector == ($past(st.sBase) | SPUR)));
endmodule

// File: rtl/picPair.sv
module picPair
  import picPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*LINES-1:0]   irqLines,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [LEN_W-1:0]     busBytes,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 cpuIrq,
  input  logic                 ackReq,
  output logic                 ackValid,
  output logic [DATA_W-1:0]    ackVector
);
  strobeT strobe;
  statusT st;

  picControl i_control (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busBytes (busBytes),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWrData(busWrData),
    .ackReq   (ackReq),
    .st       (st),
    .strobe   (strobe),
    .ackValid (ackValid),
    .ackVector(ackVector)
  );

  picDatapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .irqLines(irqLines),
    .strobe  (strobe),
    .rdData  (busRdData),
    .st      (st)
  );

  assign cpuIrq = st.mWin;

  // R7: no CPU request while the master is idle
  p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.mWin == 1'b0) |-> !cpuIrq);
endmodule

// File: tb/test_picPair.sv
`timescale 1ns/1ps
module test_picPair;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] irqLines = 0;
  logic [15:0] busAddr = 0;
  logic [2:0]  busBytes = 1;
  logic        busWr = 0, busRd = 0, ackReq = 0;
  logic [7:0]  busWrData = 0;
  logic [7:0]  busRdData, ackVector;
  logic        cpuIrq, ackValid;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  picPair i_picPair (.*);

  // ---------------- behavioural reference model ----------------
  int mIrr[2], mIsr[2], mImr[2], mTrig[2], mLast[2], mBase[2];
  int mSt[2], mNeed4[2], mSfnm[2], mAeoi[2], mRsel[2];
  bit expValid = 0;
  int expVec = 0;
  string expTag = "R9";

  function automatic int winnerOf(int c);
    int req = mIrr[c] & ~mImr[c] & 'hFF;
    int inS = mIsr[c];
    if (c == 0 && mSfnm[0] != 0) inS &= ~4;
    for (int p = 0; p < 8; p++) begin
      if ((inS >> p) & 1) return -1;
      if ((req >> p) & 1) return p;
    end
    return -1;
  endfunction

  function automatic void modelReset();
    for (int c = 0; c < 2; c++) begin
      mIrr[c] = 0; mIsr[c] = 0; mImr[c] = 0; mTrig[c] = 0; mLast[c] = 0;
      mBase[c] = 0; mSt[c] = 0; mNeed4[c] = 0; mSfnm[c] = 0; mAeoi[c] = 0; mRsel[c] = 0;
    end
    expValid = 0;
  endfunction

  function automatic void ackCore(int c, int l);
    if (((mTrig[c] >> l) & 1) == 0) mIrr[c] &= ~(1 << l);
    if (mAeoi[c] == 0) mIsr[c] |= (1 << l);
  endfunction

  function automatic int readExp(int a, int bytes);
    int c;
    if (bytes != 1) return 0;
    if (a == 'h20 || a == 'h21 || a == 'hA0 || a == 'hA1) begin
      c = (a >= 'hA0) ? 1 : 0;
      if (a & 1) return mImr[c];
      return mRsel[c] != 0 ? mIsr[c] : mIrr[c];
    end
    if (a == 'h4D0) return mTrig[0];
    if (a == 'h4D1) return mTrig[1];
    return 0;
  endfunction

  function automatic void busWrite(int a, int d);
    int c;
    if (a == 'h4D0) mTrig[0] = d & 'hF8;
    else if (a == 'h4D1) mTrig[1] = d & 'hDE;
    else if (a == 'h20 || a == 'h21 || a == 'hA0 || a == 'hA1) begin
      c = (a >= 'hA0) ? 1 : 0;
      if ((a & 1) == 0) begin
        if (d & 'h10) begin
          mIrr[c] = 0; mIsr[c] = 0; mImr[c] = 0; mBase[c] = 0; mLast[c] = 0;
          mSt[c] = 1; mNeed4[c] = d & 1; mSfnm[c] = 0; mAeoi[c] = 0; mRsel[c] = 0;
        end else if (d & 'h08) begin
          if (d & 2) mRsel[c] = d & 1;
        end else if ((d >> 5) == 1) begin
          for (int p = 0; p < 8; p++)
            if ((mIsr[c] >> p) & 1) begin mIsr[c] &= ~(1 << p); break; end
        end else if ((d >> 5) == 3) begin
          mIsr[c] &= ~(1 << (d & 7));
        end
      end else begin
        case (mSt[c])
          0: mImr[c] = d;
          1: begin mBase[c] = d & 'hF8; mSt[c] = 2; end
          2: mSt[c] = mNeed4[c] != 0 ? 3 : 0;
          default: begin mSfnm[c] = (d >> 4) & 1; mAeoi[c] = (d >> 1) & 1; mSt[c] = 0; end
        endcase
      end
    end
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    int wm, ws, ln[2];
    if (!rstN) modelReset();
    else begin
      wm = winnerOf(0);
      ws = winnerOf(1);
      ln[0] = int'(irqLines[7:0]) & ~4;
      ln[1] = int'(irqLines[15:8]);
      expValid = ackReq;
      if (ackReq) begin
        if (wm < 0) begin expVec = mBase[0] + 7; expTag = "R12"; end
        else if (wm == 2) begin
          if (ws >= 0) begin expVec = mBase[1] + ws; expTag = "R10"; end
          else begin expVec = mBase[1] + 7; expTag = "R11"; end
        end else begin expVec = mBase[0] + wm; expTag = "R9"; end
      end
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < 8; b++) begin
          if ((mTrig[c] >> b) & 1) begin
            if ((ln[c] >> b) & 1) mIrr[c] |= (1 << b); else mIrr[c] &= ~(1 << b);
          end else if (((ln[c] >> b) & 1) && !((mLast[c] >> b) & 1)) mIrr[c] |= (1 << b);
        end
      if (ws >= 0) mIrr[0] |= 4;
      if (ackReq && wm >= 0) ackCore(0, wm);
      if (ackReq && wm == 2 && ws >= 0) ackCore(1, ws);
      mLast[0] = ln[0];
      mLast[1] = ln[1];
      if (busWr && busBytes == 1) busWrite(int'(busAddr), int'(busWrData));
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R7 cpuIrq vs model", int'(cpuIrq), winnerOf(0) >= 0 ? 1 : 0);
      chk("R9 ackValid vs model", int'(ackValid), int'(expValid));
      if (expValid) chk({expTag, " ackVector vs model"}, int'(ackVector), expVec);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrB(int a, int d, int bytes);
    @(negedge clk);
    busAddr = 16'(a); busWrData = 8'(d); busBytes = 3'(bytes); busWr = 1;
    @(negedge clk);
    busWr = 0; busBytes = 1;
  endtask

  task automatic wr(int a, int d);
    wrB(a, d, 1);
  endtask

  task automatic rdB(int a, int bytes, string tag, int exp);
    @(negedge clk);
    busAddr = 16'(a); busBytes = 3'(bytes); busRd = 1;
    #1;
    chk(tag, int'(busRdData), exp);
    chk({tag, " vs model"}, int'(busRdData), readExp(a, bytes));
    busRd = 0; busBytes = 1;
  endtask

  task automatic setLines(int v);
    @(negedge clk);
    irqLines = 16'(v);
  endtask

  task automatic ackDo(string tag, int exp);
    @(negedge clk);
    ackReq = 1;
    @(negedge clk);
    ackReq = 0;
    #1;
    chk(tag, int'(ackVector), exp);
  endtask

  task automatic chkIrq(string tag, int exp);
    @(negedge clk);
    #1;
    chk(tag, int'(cpuIrq), exp);
  endtask

  task automatic initCore(int cmdA, int baseV, int w4);
    wr(cmdA, 'h11);
    wr(cmdA + 1, baseV);
    wr(cmdA + 1, 0);
    wr(cmdA + 1, w4);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    #1;
    chk("R1 cpuIrq in reset", int'(cpuIrq), 0);
    rstN = 1;
    // R1: reset state
    chkIrq("R1 cpuIrq after reset", 0);
    chk("R1 ackValid after reset", int'(ackValid), 0);
    rdB('h20, 1, "R1 master request", 0);
    rdB('h21, 1, "R1 master mask", 0);
    rdB('hA1, 1, "R1 slave mask", 0);
    rdB('h4D0, 1, "R1 master trigger", 0);

    // R13: initialisation, base bits 2:0 dropped
    initCore('h20, 'h08, 'h01);
    initCore('hA0, 'h75, 'h01);
    rdB('h21, 1, "R13 mask after init", 0);

    // R12: nothing pending
    ackDo("R12 master spurious", 'h0F);

    // R5/R9: edge line 3
    setLines('h0008);
    idle(1);
    chkIrq("R7 cpuIrq on edge", 1);
    ackDo("R9 master vector line 3", 'h0B);
    setLines(0);
    wr('h20, 'h0B);
    rdB('h20, 1, "R9 in-service after ack", 'h08);
    wr('h20, 'h20);
    rdB('h20, 1, "R13 non-specific EOI", 'h00);

    // R6: priority and in-service blocking
    setLines('h0022);
    idle(2);
    ackDo("R6 line 1 beats line 5", 'h09);
    ackDo("R6 line 5 blocked by in-service 1", 'h0F);
    wr('h20, 'h20);
    ackDo("R6 line 5 after EOI", 'h0D);
    wr('h20, 'h20);
    setLines(0);

    // R6: masking
    wr('h21, 'h10);
    setLines('h0010);
    idle(2);
    chkIrq("R6 masked line no irq", 0);
    wr('h21, 'h00);
    chkIrq("R6 unmasked line irq", 1);
    ackDo("R9 line 4 vector", 'h0C);
    wr('h20, 'h64);
    rdB('h20, 1, "R13 specific EOI", 'h00);
    setLines(0);

    // R8/R10: slave request through cascade
    setLines('h1000);
    idle(3);
    ackDo("R10 slave vector line 4", 'h74);
    wr('hA0, 'h0B);
    rdB('hA0, 1, "R10 slave in-service", 'h10);
    rdB('h20, 1, "R10 master in-service line 2", 'h04);
    wr('hA0, 'h20);
    wr('h20, 'h20);
    setLines(0);

    // R11: slave request withdrawn before acknowledge
    setLines('h0200);
    idle(3);
    wr('hA1, 'h02);
    idle(1);
    ackDo("R11 slave spurious", 'h77);
    wr('h20, 'h20);
    wr('hA1, 'h00);
    idle(2);
    ackDo("R10 slave line 1 after unmask", 'h71);
    wr('hA0, 'h20);
    wr('h20, 'h20);
    setLines(0);

    // R3: trigger masks
    wr('h4D0, 'hFF);
    rdB('h4D0, 1, "R3 master trigger mask", 'hF8);
    wr('h4D1, 'hFF);
    rdB('h4D1, 1, "R3 slave trigger mask", 'hDE);

    // R5: level line keeps its request through acknowledge
    setLines('h0008);
    idle(2);
    ackDo("R9 level line 3 vector", 'h0B);
    wr('h20, 'h0A);
    rdB('h20, 1, "R5 level request held", 'h08);
    setLines(0);
    idle(1);
    rdB('h20, 1, "R5 level request follows low", 'h00);
    wr('h20, 'h20);
    wr('h4D0, 0);
    wr('h4D1, 0);

    // R4/R2: size and address filtering
    wrB('h21, 'hFF, 2);
    rdB('h21, 1, "R4 wide write ignored", 'h00);
    wr('h21, 'h81);
    rdB('h21, 2, "R4 wide read returns 0", 'h00);
    rdB('h21, 1, "R2 master data port", 'h81);
    wr('h21, 0);
    wr('h22, 'h55);
    rdB('h22, 1, "R2 unmapped read", 'h00);
    rdB('h21, 1, "R2 unmapped write ignored", 'h00);

    // R14: auto-EOI
    initCore('h20, 'h08, 'h02);
    setLines('h0040);
    idle(2);
    ackDo("R14 auto-EOI vector", 'h0E);
    wr('h20, 'h0B);
    rdB('h20, 1, "R14 no in-service set", 'h00);
    setLines(0);

    // R6: nested mode lets a higher slave line through
    initCore('h20, 'h08, 'h10);
    setLines('h2000);
    idle(3);
    ackDo("R10 slave line 5", 'h75);
    setLines('h2800);
    idle(3);
    chkIrq("R6 nested mode higher slave line", 1);
    ackDo("R10 slave line 3 nested", 'h73);
    setLines(0);
    idle(3);
    finishRun();
  end
endmodule